// File: doc/BRIEF.md
# Memory Protection Region Checker

This block decides, for every bus access, whether the issuing master may touch the addressed location. It holds twelve region descriptors. Each descriptor has a start address, an end address, a packed rights word and a valid flag. A plain register write port programs the descriptors. Each access presents a master number, an address, an access kind and a privilege flag. In the same cycle the block reports whether any valid region covers the address (`acc_hit`), whether the access is allowed (`acc_ok`) and the inverse of that as an error flag (`acc_err`).

Region bounds work on 32-byte granules. The start address keeps bits 31..5, and its low five bits count as zero. The end address also keeps bits 31..5, and its low five bits count as ones, so a region always ends on the last byte of a granule. Masters 0..3 carry a five-bit rights field that distinguishes user from supervisor mode. Masters 4..7 carry only a read-enable bit and a write-enable bit. When regions overlap, the access is allowed if any region that covers it grants it.

Reprogramming a region's end address drops that region's valid flag. Software must then re-enable the region explicitly, so a half-programmed region is never active.

Top module: `mem_region_guard`

## Requirements
- R1: After reset only region 0 is valid. It covers 0x00000000..0xFFFFFFFF and grants every kind of access to every master in both privilege modes.
- R2: A register write selects the region with `cfg_addr[7:4]` and the word with `cfg_addr[3:2]`. Word 0 is the start, word 1 is the end, word 2 is rights and word 3 is control, with the valid flag in bit 0. Writes whose region index is 12..15 change nothing.
- R3: The effective start is `{wdata[31:5],5'b00000}` and the effective end is `{wdata[31:5],5'b11111}`. An address matches when start <= address <= end and the region is valid.
- R4: Writing word 1 of a region clears its valid flag. Writing word 3 loads the flag from `cfg_wdata[0]`. Writes to words 0 and 2 leave the flag unchanged.
- R5: The end is not checked against the start. A region whose end lies below its start never matches.
- R6: For masters m = 0..3, the rights field is `rights[5m+4:5m]`. In user mode, bit 2 grants read, bit 1 grants write and bit 0 grants execute. The access kind `acc_type` is encoded 00 = data read, 01 = data write, 10 = instruction fetch.
- R7: For masters 0..3 in supervisor mode, field bits [4:3] select the rights. 00 gives the user rights, 01 gives read+execute, 10 gives read only and 11 gives read+write+execute.
- R8: For masters m = 4..7, bit `20+2(m-4)` enables read and bit `21+2(m-4)` enables write. An instruction fetch is allowed only when the read bit is set. The privilege flag has no effect for these masters.
- R9: An access that matches no valid region gives `acc_hit`=0, `acc_ok`=0 and `acc_err`=1 combinationally, in the same cycle.
- R10: When several valid regions match, the access is allowed if at least one of them grants it.
- R11: `acc_type` = 11 is denied in every region.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_addr | input | 8 | Byte offset of the descriptor word |
| cfg_wdata | input | 32 | Descriptor write data |
| acc_master | input | 3 | Master number of the access |
| acc_addr | input | 32 | Access address |
| acc_type | input | 2 | Access kind (00 read, 01 write, 10 fetch) |
| acc_super | input | 1 | 1 = supervisor mode, 0 = user mode |
| acc_hit | output | 1 | Some valid region covers the address |
| acc_ok | output | 1 | Access allowed |
| acc_err | output | 1 | Access denied |

## Verification
The bench probes the first and last byte of a granule and the byte after the end of a region. A design that compared raw addresses, or padded the end with zeros, would cut the region short or extend it by a granule. It rewrites an end word and checks that the region drops out until it is re-enabled. It also checks that rights and start writes do not revive the region; a design missing the invalidation would keep granting accesses during reprogramming. It steps through all four supervisor codes, the two-bit masters with fetch and privilege combinations, inverted bounds, overlapping regions and writes to unimplemented region indices. Each of these catches a decode that is off by a bit, or an index that aliases onto a real region.

// File: rtl/mrg_pkg.sv
package mrg_pkg;

    localparam int ADDR_W      = 32;
    localparam int GRAN_W      = 5;
    localparam int BASE_W      = ADDR_W - GRAN_W;
    localparam int HI_MASTERS  = 4;
    localparam int LO_MASTERS  = 4;
    localparam int HI_FIELD_W  = 5;
    localparam int LO_FIELD_W  = 2;
    localparam int NUM_MASTERS = HI_MASTERS + LO_MASTERS;
    localparam int MASTER_W    = $clog2(NUM_MASTERS);
    localparam int RIGHTS_W    = HI_MASTERS * HI_FIELD_W + LO_MASTERS * LO_FIELD_W;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_EXEC  = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_kind_e;

    typedef struct packed {
        logic [BASE_W-1:0]   start_base;
        logic [BASE_W-1:0]   end_base;
        logic [RIGHTS_W-1:0] rights;
        logic                valid;
    } region_desc_t;

endpackage

// File: rtl/mrg_desc_regs.sv
module mrg_desc_regs
    import mrg_pkg::*;
#(
    parameter int NUM_REGIONS = 12,
    localparam int IDX_W      = $clog2(NUM_REGIONS),
    localparam int CFG_AW     = IDX_W + 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [CFG_AW-1:0]             cfg_addr,
    input  logic [ADDR_W-1:0]             cfg_wdata,
    output region_desc_t [NUM_REGIONS-1:0] desc_o
);

    typedef struct packed {
        region_desc_t [NUM_REGIONS-1:0] desc;
    } regs_state_t;

    regs_state_t state_d, state_q;

    logic [IDX_W-1:0] sel_idx;
    logic [1:0]       sel_word;
    logic [1:0]       unused_byte_lane;

    assign sel_idx          = cfg_addr[CFG_AW-1:4];
    assign sel_word         = cfg_addr[3:2];
    assign unused_byte_lane = cfg_addr[1:0];

    function automatic regs_state_t reset_state();
        regs_state_t s;
        s = '0;
        s.desc[0].start_base = '0;
        s.desc[0].end_base   = '1;
        s.desc[0].rights     = '1;
        s.desc[0].valid      = 1'b1;
        return s;
    endfunction

    always_comb begin
        state_d = state_q;
        for (int r = 0; r < NUM_REGIONS; r++) begin
            if (cfg_we && (int'(sel_idx) == r)) begin
                case (sel_word)
                    2'd0: state_d.desc[r].start_base = cfg_wdata[ADDR_W-1:GRAN_W];
                    2'd1: begin
                        state_d.desc[r].end_base = cfg_wdata[ADDR_W-1:GRAN_W];
                        state_d.desc[r].valid    = 1'b0;
                    end
                    2'd2: state_d.desc[r].rights = cfg_wdata[RIGHTS_W-1:0];
                    default: state_d.desc[r].valid = cfg_wdata[0];
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= reset_state();
        else        state_q <= state_d;
    end

    assign desc_o = state_q.desc;

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_chk
        // R4: an end-address write leaves the region disabled
        a_r4_end_write_clears_valid: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && int'(sel_idx) == g && sel_word == 2'd1) |=> !state_q.desc[g].valid);
        // R4 / R2: only end or control writes to this region move the flag
        a_r4_valid_stable_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
            !(cfg_we && int'(sel_idx) == g && (sel_word == 2'd1 || sel_word == 2'd3))
            |=> $stable(state_q.desc[g].valid));
    end

endmodule

// File: rtl/mrg_perm_decode.sv
module mrg_perm_decode
    import mrg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [MASTER_W-1:0] master,
    input  logic [1:0]          kind,
    input  logic                super_mode,
    input  logic [RIGHTS_W-1:0] rights,
    output logic                allow
);

    logic                  is_hi;
    logic [HI_FIELD_W-1:0] hi_field;
    logic [LO_FIELD_W-1:0] lo_field;
    logic                  p_rd, p_wr, p_ex;

    assign is_hi = int'(master) < HI_MASTERS;

    always_comb begin
        hi_field = '0;
        lo_field = '0;
        p_rd     = 1'b0;
        p_wr     = 1'b0;
        p_ex     = 1'b0;
        if (is_hi) begin
            hi_field = rights[int'(master) * HI_FIELD_W +: HI_FIELD_W];
            if (!super_mode || hi_field[4:3] == 2'b00) begin
                p_rd = hi_field[2];
                p_wr = hi_field[1];
                p_ex = hi_field[0];
            end else begin
                case (hi_field[4:3])
                    2'b01:   begin p_rd = 1'b1; p_ex = 1'b1; end
                    2'b10:   begin p_rd = 1'b1; end
                    default: begin p_rd = 1'b1; p_wr = 1'b1; p_ex = 1'b1; end
                endcase
            end
        end else begin
            lo_field = rights[HI_MASTERS * HI_FIELD_W
                              + (int'(master) - HI_MASTERS) * LO_FIELD_W +: LO_FIELD_W];
            p_rd = lo_field[0];
            p_wr = lo_field[1];
            p_ex = lo_field[0];
        end
    end

    always_comb begin
        case (kind)
            ACC_READ:  allow = p_rd;
            ACC_WRITE: allow = p_wr;
            ACC_EXEC:  allow = p_ex;
            default:   allow = 1'b0;
        endcase
    end

    // R11: reserved kind is never granted
    a_r11_rsvd_denied: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_RSVD) |-> !allow);
    // R7: supervisor code 11 grants every defined kind
    a_r7_super_full: assert property (@(posedge clk) disable iff (!rst_n)
        (is_hi && super_mode && rights[int'(master) * HI_FIELD_W + 3 +: 2] == 2'b11
         && kind != ACC_RSVD) |-> allow);
    // R8: a fetch by a two-bit master needs its read bit
    a_r8_lo_fetch_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_hi && kind == ACC_EXEC && allow)
        |-> rights[HI_MASTERS * HI_FIELD_W + (int'(master) - HI_MASTERS) * LO_FIELD_W]);

endmodule

// File: rtl/mrg_region_eval.sv
module mrg_region_eval
    import mrg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  region_desc_t        desc,
    input  logic [MASTER_W-1:0] acc_master,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic [1:0]          acc_type,
    input  logic                acc_super,
    output logic                hit,
    output logic                allow
);

    logic [ADDR_W-1:0] start_full;
    logic [ADDR_W-1:0] end_full;
    logic              perm_ok;

    assign start_full = {desc.start_base, {GRAN_W{1'b0}}};
    assign end_full   = {desc.end_base,   {GRAN_W{1'b1}}};

    assign hit   = desc.valid && (acc_addr >= start_full) && (acc_addr <= end_full);
    assign allow = hit && perm_ok;

    mrg_perm_decode i_perm (
        .clk        (clk),
        .rst_n      (rst_n),
        .master     (acc_master),
        .kind       (acc_type),
        .super_mode (acc_super),
        .rights     (desc.rights),
        .allow      (perm_ok)
    );

    // R5: inverted bounds never match
    a_r5_inverted_never_hits: assert property (@(posedge clk) disable iff (!rst_n)
        (desc.end_base < desc.start_base) |-> !hit);
    // R3: a match never lies outside the stored granule bounds
    a_r3_hit_inside_bases: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (acc_addr[ADDR_W-1:GRAN_W] >= desc.start_base
                 && acc_addr[ADDR_W-1:GRAN_W] <= desc.end_base));

endmodule

// File: rtl/mem_region_guard.sv
module mem_region_guard
    import mrg_pkg::*;
#(
    parameter int NUM_REGIONS = 12,
    localparam int CFG_AW     = $clog2(NUM_REGIONS) + 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [ADDR_W-1:0]   cfg_wdata,
    input  logic [MASTER_W-1:0] acc_master,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic [1:0]          acc_type,
    input  logic                acc_super,
    output logic                acc_hit,
    output logic                acc_ok,
    output logic                acc_err
);

    region_desc_t [NUM_REGIONS-1:0] desc;
    logic [NUM_REGIONS-1:0]         hit_vec;
    logic [NUM_REGIONS-1:0]         allow_vec;

    mrg_desc_regs #(.NUM_REGIONS(NUM_REGIONS)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .desc_o    (desc)
    );

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        mrg_region_eval i_eval (
            .clk        (clk),
            .rst_n      (rst_n),
            .desc       (desc[g]),
            .acc_master (acc_master),
            .acc_addr   (acc_addr),
            .acc_type   (acc_type),
            .acc_super  (acc_super),
            .hit        (hit_vec[g]),
            .allow      (allow_vec[g])
        );
    end

    assign acc_hit = |hit_vec;
    assign acc_ok  = |allow_vec;
    assign acc_err = ~acc_ok;

    // R9: an unmatched access is denied and flagged
    a_r9_miss_denied: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_hit |-> (!acc_ok && acc_err));

endmodule

// File: tb/test_mem_region_guard.sv
module test_mem_region_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [2:0]  acc_master = '0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_type = '0;
    logic        acc_super = 1'b0;
    logic        acc_hit, acc_ok, acc_err;

    int n_checks = 0;
    int n_fails  = 0;

    localparam logic [1:0] RD = 2'b00, WR = 2'b01, EX = 2'b10, RS = 2'b11;

    always #2.5 clk = ~clk;

    mem_region_guard i_mem_region_guard (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .acc_master(acc_master), .acc_addr(acc_addr),
        .acc_type(acc_type), .acc_super(acc_super),
        .acc_hit(acc_hit), .acc_ok(acc_ok), .acc_err(acc_err)
    );

    function automatic logic [7:0] ra(int region, int word);
        return 8'(region * 16 + word * 4);
    endfunction

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [2:0] m, input logic [31:0] a,
                       input logic [1:0] k, input logic s, input logic eh, input logic eo);
        @(negedge clk);
        acc_master = m; acc_addr = a; acc_type = k; acc_super = s;
        #1;
        n_checks++;
        if (acc_hit !== eh || acc_ok !== eo || acc_err !== !eo) begin
            n_fails++;
            $display("FAIL %s m=%0d a=%h k=%0d s=%0b: hit/ok/err=%b%b%b expected %b%b%b",
                     tag, m, a, k, s, acc_hit, acc_ok, acc_err, eh, eo, !eo);
        end
    endtask

    task automatic t_reset;
        chk("R1", 3'd0, 32'h0000_0000, RD, 1'b0, 1'b1, 1'b1);
        chk("R1", 3'd3, 32'hFFFF_FFFF, WR, 1'b1, 1'b1, 1'b1);
        chk("R1", 3'd7, 32'h8000_0000, EX, 1'b0, 1'b1, 1'b1);
        chk("R1", 3'd5, 32'h1234_5678, WR, 1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_unmapped;
        wr_reg(ra(0, 3), 32'h0);
        chk("R9", 3'd0, 32'h0000_0000, RD, 1'b0, 1'b0, 1'b0);
        chk("R9", 3'd6, 32'hC000_0000, WR, 1'b1, 1'b0, 1'b0);
        wr_reg(ra(12, 2), 32'hFFFF_FFFF);
        wr_reg(ra(12, 3), 32'h1);
        wr_reg(ra(15, 3), 32'h1);
        chk("R2", 3'd0, 32'h0000_0000, RD, 1'b0, 1'b0, 1'b0);
        chk("R2", 3'd0, 32'h0000_0010, RD, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_granule;
        wr_reg(ra(1, 0), 32'h1000_0010);
        wr_reg(ra(1, 1), 32'h1000_0040);
        wr_reg(ra(1, 2), 32'h0000_0007);
        wr_reg(ra(1, 3), 32'h1);
        chk("R3", 3'd0, 32'h1000_0000, RD, 1'b0, 1'b1, 1'b1);
        chk("R3", 3'd0, 32'h0FFF_FFFF, RD, 1'b0, 1'b0, 1'b0);
        chk("R3", 3'd0, 32'h1000_005F, RD, 1'b0, 1'b1, 1'b1);
        chk("R3", 3'd0, 32'h1000_0060, RD, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_valid;
        wr_reg(ra(1, 1), 32'h1000_0040);
        chk("R4", 3'd0, 32'h1000_0000, RD, 1'b0, 1'b0, 1'b0);
        wr_reg(ra(1, 0), 32'h1000_0000);
        wr_reg(ra(1, 2), 32'h0000_0007);
        chk("R4", 3'd0, 32'h1000_0000, RD, 1'b0, 1'b0, 1'b0);
        wr_reg(ra(1, 3), 32'h1);
        chk("R4", 3'd0, 32'h1000_0000, RD, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_inverted;
        wr_reg(ra(2, 0), 32'h2000_0100);
        wr_reg(ra(2, 1), 32'h2000_0000);
        wr_reg(ra(2, 2), 32'h0FFF_FFFF);
        wr_reg(ra(2, 3), 32'h1);
        chk("R5", 3'd0, 32'h2000_0010, RD, 1'b0, 1'b0, 1'b0);
        chk("R5", 3'd0, 32'h2000_0100, RD, 1'b0, 1'b0, 1'b0);
        chk("R5", 3'd0, 32'h2000_001F, RD, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_user;
        wr_reg(ra(1, 2), 32'h0000_00A0);
        chk("R6", 3'd1, 32'h1000_0020, RD, 1'b0, 1'b1, 1'b1);
        chk("R6", 3'd1, 32'h1000_0020, WR, 1'b0, 1'b1, 1'b0);
        chk("R6", 3'd1, 32'h1000_0020, EX, 1'b0, 1'b1, 1'b1);
        chk("R6", 3'd0, 32'h1000_0020, RD, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_super;
        logic [2:0] er [4];
        logic [2:0] ew [4];
        // expected {read, write, exec} per supervisor code, user rights = write only
        er[0] = 3'b010; er[1] = 3'b101; er[2] = 3'b100; er[3] = 3'b111;
        for (int c = 0; c < 4; c++) begin
            ew[c] = er[c];
            wr_reg(ra(1, 2), 32'({2'(c), 3'b010}) << 5);
            chk("R7", 3'd1, 32'h1000_0004, RD, 1'b1, 1'b1, ew[c][2]);
            chk("R7", 3'd1, 32'h1000_0004, WR, 1'b1, 1'b1, ew[c][1]);
            chk("R7", 3'd1, 32'h1000_0004, EX, 1'b1, 1'b1, ew[c][0]);
        end
        chk("R7", 3'd1, 32'h1000_0004, RD, 1'b0, 1'b1, 1'b0);
        chk("R7", 3'd1, 32'h1000_0004, WR, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_lo;
        wr_reg(ra(1, 2), 32'h1 << 22);
        chk("R8", 3'd5, 32'h1000_0008, RD, 1'b0, 1'b1, 1'b1);
        chk("R8", 3'd5, 32'h1000_0008, RD, 1'b1, 1'b1, 1'b1);
        chk("R8", 3'd5, 32'h1000_0008, WR, 1'b1, 1'b1, 1'b0);
        chk("R8", 3'd5, 32'h1000_0008, EX, 1'b0, 1'b1, 1'b1);
        chk("R8", 3'd4, 32'h1000_0008, RD, 1'b0, 1'b1, 1'b0);
        wr_reg(ra(1, 2), 32'h1 << 23);
        chk("R8", 3'd5, 32'h1000_0008, WR, 1'b0, 1'b1, 1'b1);
        chk("R8", 3'd5, 32'h1000_0008, RD, 1'b1, 1'b1, 1'b0);
        chk("R8", 3'd5, 32'h1000_0008, EX, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_overlap;
        wr_reg(ra(1, 2), 32'h0000_1000);
        wr_reg(ra(3, 0), 32'h1000_0000);
        wr_reg(ra(3, 1), 32'h1000_005F);
        wr_reg(ra(3, 2), 32'h0000_0800);
        wr_reg(ra(3, 3), 32'h1);
        chk("R10", 3'd2, 32'h1000_0040, RD, 1'b0, 1'b1, 1'b1);
        chk("R10", 3'd2, 32'h1000_0040, WR, 1'b0, 1'b1, 1'b1);
        chk("R10", 3'd2, 32'h1000_0040, EX, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_rsvd;
        wr_reg(ra(1, 2), 32'h0FFF_FFFF);
        chk("R11", 3'd0, 32'h1000_0000, RS, 1'b1, 1'b1, 1'b0);
        chk("R11", 3'd6, 32'h1000_0000, RS, 1'b0, 1'b1, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_unmapped();
        t_granule();
        t_valid();
        t_inverted();
        t_user();
        t_super();
        t_lo();
        t_overlap();
        t_rsvd();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule